// File: doc/BRIEF.md
# Reset Sequencing Controller

This block produces the internal reset of a small microcontroller core. Several sources can request a reset: a power-on pulse, an active-low external reset pin, a brown-out comparator flag and an internal watchdog. Once every source is quiet, the block keeps the core in reset while two timers run one after the other. The first is an optional power-up delay, counted in ticks of a slow clock. The second is an oscillator start-up count, counted in cycles of the main clock. Only after both have finished does the internal reset release.

Two of the sources are filtered before they can act. A brown-out flag must stay high for a minimum number of slow ticks. An external reset must stay low for a minimum number of main-clock cycles. Shorter events are rejected. A sticky cause register shows which kinds of reset have occurred since the last power-on. An I/O tri-state enable goes high on an external or watchdog reset and stays high until reset releases. The watchdog counts slow ticks while the core runs. Software restarts it with a clear strobe, and if it is not cleared in time it forces a reset.

Everything is clocked by the main oscillator clock `clk`. The slow clock reaches the block as a one-cycle enable `slowTick`. The power-on pulse `porPulse` is the asynchronous reset of all state.

Top module: `rstseq_top`

## Requirements
- R1: While `porPulse` is high and on its release, the outputs are: `rstN`=0, `resetCause`=4'b0001, `ioHiZ`=0 and `wdtCount`=0.
- R2: When `pwrtEnN`=0 at the moment the sources go quiet, the power-up phase comes first and lasts PWRT_TICKS slow ticks. With no slow ticks, reset stays asserted indefinitely. When `pwrtEnN`=1, this phase is skipped.
- R3: The oscillator start-up phase lasts exactly OST_CYCLES main-clock cycles. With `pwrtEnN`=1 and no other source active, `rstN` rises on clock edge OST_CYCLES+1 after `porPulse` falls.
- R4: A brown-out resets the core only once `brownFlag` has been high for BOR_TICKS consecutive slow ticks. A shorter high pulse has no effect on `rstN` or `resetCause`.
- R5: An external reset takes effect only once `extRstN` has been low for MCLR_MIN consecutive clock cycles. A shorter low pulse has no effect.
- R6: While `rstN`=1, `wdtCount` increments on each slow tick. `wdtClr` returns it to 0. When it reaches WDT_TICKS, reset asserts on the next edge. While `rstN`=0, `wdtCount` is held at 0.
- R7: A brown-out, power-on or external reset arriving during either timer phase restarts the sequence. The full start-up count is run again once the source releases.
- R8: `resetCause` is sticky. Bit 0 marks power-on, bit 1 brown-out, bit 2 external reset and bit 3 watchdog. Its bits never clear except on power-on, which sets it to 4'b0001.
- R9: `ioHiZ` rises with an external or watchdog reset, stays high only while `rstN`=0, and falls when reset releases. A brown-out does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| porPulse | input | 1 | Power-on reset pulse, active high, asynchronous |
| extRstN | input | 1 | External reset pin, active low |
| brownFlag | input | 1 | Brown-out comparator output, high while supply is low |
| wdtClr | input | 1 | Watchdog clear strobe |
| pwrtEnN | input | 1 | Power-up delay enable, 0 enables the delay |
| slowTick | input | 1 | One-cycle enable at the slow clock rate |
| rstN | output | 1 | Internal core reset, active low |
| ioHiZ | output | 1 | I/O tri-state enable |
| resetCause | output | 4 | Sticky reset cause flags |
| wdtCount | output | $clog2(WDT_TICKS+1) | Watchdog counter value |

## Verification
The assertions assume that `slowTick`, `brownFlag`, `extRstN` and `wdtClr` are already synchronous to `clk`, and that `porPulse` is the only asynchronous input. They also assume `slowTick` is a plain enable, never a second clock. The bench drives every input one nanosecond after a rising edge and samples the outputs at that same point. This keeps every event one clean cycle wide. The sweeps hold `slowTick` high so that tick counts equal cycle counts. During the brown-out and external-reset sweeps, `wdtClr` stays asserted so the watchdog cannot interfere.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_PWRT = 2'd1,
    ST_OST  = 2'd2,
    ST_RUN  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic wdtRun;
  } seqStrobe_t;
endpackage

// File: rtl/rstseq_qual.sv
// Minimum-duration qualifier: counts enabled cycles while the source is active.
module rstseq_qual #(
  parameter int LIMIT = 3,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic porPulse,
  input  logic active,
  input  logic en,
  output logic hit
);
  logic [CW-1:0] runLen;

  always_ff @(posedge clk or posedge porPulse) begin
    if (porPulse)                           runLen <= '0;
    else if (!active)                       runLen <= '0;
    else if (en && runLen != CW'(LIMIT))    runLen <= runLen + 1'b1;
  end

  assign hit = (runLen == CW'(LIMIT));

  assert_hit_needs_source_R4: assert property (@(posedge clk) disable iff (porPulse)
    hit |-> $past(active));
endmodule

// File: rtl/rstseq_datapath.sv
module rstseq_datapath import rstseq_pkg::*; #(
  parameter int BOR_TICKS = 3,
  parameter int MCLR_MIN  = 3,
  parameter int WDT_TICKS = 512,
  parameter int PH_W      = 11,
  parameter int WDT_W     = 10
) (
  input  logic             clk,
  input  logic             porPulse,
  input  logic             extRstN,
  input  logic             brownFlag,
  input  logic             slowTick,
  input  logic             wdtClr,
  input  seqStrobe_t       strobe,
  output logic             borHit,
  output logic             mclrHit,
  output logic             wdtHit,
  output logic [PH_W-1:0]  phaseCnt,
  output logic [WDT_W-1:0] wdtCount
);
  // Two duration qualifiers share one structure; the variant picks enable and limit.
  logic [1:0] qualActive, qualEn, qualHit;
  assign qualActive = {!extRstN, brownFlag};
  assign qualEn     = {1'b1, slowTick};

  for (genvar g = 0; g < 2; g++) begin : gQual
    rstseq_qual #(.LIMIT(g == 0 ? BOR_TICKS : MCLR_MIN)) uQual (
      .clk(clk), .porPulse(porPulse),
      .active(qualActive[g]), .en(qualEn[g]), .hit(qualHit[g])
    );
  end

  assign borHit  = qualHit[0];
  assign mclrHit = qualHit[1];

  // Shared phase counter for the power-up and start-up timers.
  always_ff @(posedge clk or posedge porPulse) begin
    if (porPulse)           phaseCnt <= '0;
    else if (strobe.cntClr) phaseCnt <= '0;
    else if (strobe.cntInc) phaseCnt <= phaseCnt + 1'b1;
  end

  assign wdtHit = (wdtCount == WDT_W'(WDT_TICKS));

  always_ff @(posedge clk or posedge porPulse) begin
    if (porPulse)                              wdtCount <= '0;
    else if (!strobe.wdtRun || wdtClr || wdtHit) wdtCount <= '0;
    else if (slowTick)                         wdtCount <= wdtCount + 1'b1;
  end

  assert_wdt_held_R6: assert property (@(posedge clk) disable iff (porPulse)
    !strobe.wdtRun |=> wdtCount == '0);
  assert_mclr_qualified_R5: assert property (@(posedge clk) disable iff (porPulse)
    mclrHit |-> $past(!extRstN));
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl import rstseq_pkg::*; #(
  parameter int PWRT_TICKS = 1984,
  parameter int OST_CYCLES = 1024,
  parameter int PH_W       = 11
) (
  input  logic            clk,
  input  logic            porPulse,
  input  logic            pwrtEnN,
  input  logic            slowTick,
  input  logic            borHit,
  input  logic            mclrHit,
  input  logic            wdtHit,
  input  logic [PH_W-1:0] phaseCnt,
  output seqStrobe_t      strobe,
  output logic            rstN,
  output logic            ioHiZ,
  output logic [3:0]      resetCause
);
  seqState_t state, nextState;
  logic trig, pwrtLast, ostLast, releasing;

  assign trig     = borHit | mclrHit | wdtHit;
  assign pwrtLast = (phaseCnt == PH_W'(PWRT_TICKS - 1));
  assign ostLast  = (phaseCnt == PH_W'(OST_CYCLES - 1));

  always_comb begin
    nextState     = state;
    strobe        = '0;
    strobe.wdtRun = (state == ST_RUN);
    releasing     = 1'b0;
    case (state)
      ST_HOLD: begin
        strobe.cntClr = 1'b1;
        if (!trig) nextState = pwrtEnN ? ST_OST : ST_PWRT;
      end
      ST_PWRT: begin
        if (trig) begin
          nextState = ST_HOLD; strobe.cntClr = 1'b1;
        end else if (slowTick) begin
          if (pwrtLast) begin
            nextState = ST_OST; strobe.cntClr = 1'b1;
          end else strobe.cntInc = 1'b1;
        end
      end
      ST_OST: begin
        if (trig) begin
          nextState = ST_HOLD; strobe.cntClr = 1'b1;
        end else if (ostLast) begin
          nextState = ST_RUN; strobe.cntClr = 1'b1; releasing = 1'b1;
        end else strobe.cntInc = 1'b1;
      end
      default: begin
        if (trig) begin
          nextState = ST_HOLD; strobe.cntClr = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or posedge porPulse) begin
    if (porPulse) begin
      state      <= ST_HOLD;
      ioHiZ      <= 1'b0;
      resetCause <= 4'b0001;
    end else begin
      state      <= nextState;
      resetCause <= resetCause | {wdtHit, mclrHit, borHit, 1'b0};
      if (mclrHit || wdtHit) ioHiZ <= 1'b1;
      else if (releasing)    ioHiZ <= 1'b0;
    end
  end

  assign rstN = (state == ST_RUN);

  assert_release_after_ost_R3: assert property (@(posedge clk) disable iff (porPulse)
    $rose(rstN) |-> $past(state == ST_OST));
  assert_trigger_resets_R7: assert property (@(posedge clk) disable iff (porPulse)
    trig |=> !rstN);
  assert_cause_sticky_R8: assert property (@(posedge clk) disable iff (porPulse)
    (resetCause & $past(resetCause)) == $past(resetCause));
  assert_hiz_in_reset_R9: assert property (@(posedge clk) disable iff (porPulse)
    ioHiZ |-> !rstN);
  assert_pwrt_gated_R2: assert property (@(posedge clk) disable iff (porPulse)
    (state == ST_PWRT && !slowTick && !trig) |=> state == ST_PWRT);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top import rstseq_pkg::*; #(
  parameter int PWRT_TICKS = 1984,
  parameter int OST_CYCLES = 1024,
  parameter int BOR_TICKS  = 3,
  parameter int MCLR_MIN   = 8,
  parameter int WDT_TICKS  = 496,
  localparam int PH_MAX    = (PWRT_TICKS > OST_CYCLES) ? PWRT_TICKS : OST_CYCLES,
  localparam int PH_W      = $clog2(PH_MAX + 1),
  localparam int WDT_W     = $clog2(WDT_TICKS + 1)
) (
  input  logic             clk,
  input  logic             porPulse,
  input  logic             extRstN,
  input  logic             brownFlag,
  input  logic             wdtClr,
  input  logic             pwrtEnN,
  input  logic             slowTick,
  output logic             rstN,
  output logic             ioHiZ,
  output logic [3:0]       resetCause,
  output logic [WDT_W-1:0] wdtCount
);
  seqStrobe_t      strobe;
  logic            borHit, mclrHit, wdtHit;
  logic [PH_W-1:0] phaseCnt;

  rstseq_datapath #(
    .BOR_TICKS(BOR_TICKS), .MCLR_MIN(MCLR_MIN), .WDT_TICKS(WDT_TICKS),
    .PH_W(PH_W), .WDT_W(WDT_W)
  ) uPath (
    .clk(clk), .porPulse(porPulse), .extRstN(extRstN), .brownFlag(brownFlag),
    .slowTick(slowTick), .wdtClr(wdtClr), .strobe(strobe),
    .borHit(borHit), .mclrHit(mclrHit), .wdtHit(wdtHit),
    .phaseCnt(phaseCnt), .wdtCount(wdtCount)
  );

  rstseq_ctrl #(
    .PWRT_TICKS(PWRT_TICKS), .OST_CYCLES(OST_CYCLES), .PH_W(PH_W)
  ) uCtrl (
    .clk(clk), .porPulse(porPulse), .pwrtEnN(pwrtEnN), .slowTick(slowTick),
    .borHit(borHit), .mclrHit(mclrHit), .wdtHit(wdtHit), .phaseCnt(phaseCnt),
    .strobe(strobe), .rstN(rstN), .ioHiZ(ioHiZ), .resetCause(resetCause)
  );
endmodule

// File: tb/sim_rstseq_top.sv
`timescale 1ns/1ps
module sim_rstseq_top;
  localparam int PWRT = 5, OST = 8, BOR = 3, MCL = 3, WDT = 6;
  localparam int WW = $clog2(WDT + 1);

  logic clk = 1'b0;
  logic porPulse = 1'b1, extRstN = 1'b1, brownFlag = 1'b0;
  logic wdtClr = 1'b0, pwrtEnN = 1'b1, slowTick = 1'b0;
  logic rstN, ioHiZ;
  logic [3:0] resetCause;
  logic [WW-1:0] wdtCount;
  int nChecks = 0, nFails = 0, cyc = 0;

  always #2 clk = ~clk;

  rstseq_top #(.PWRT_TICKS(PWRT), .OST_CYCLES(OST), .BOR_TICKS(BOR),
               .MCLR_MIN(MCL), .WDT_TICKS(WDT)) u0 (
    .clk(clk), .porPulse(porPulse), .extRstN(extRstN), .brownFlag(brownFlag),
    .wdtClr(wdtClr), .pwrtEnN(pwrtEnN), .slowTick(slowTick),
    .rstN(rstN), .ioHiZ(ioHiZ), .resetCause(resetCause), .wdtCount(wdtCount));

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic doPor();
    porPulse = 1'b1; tick(); tick();
    porPulse = 1'b0;
  endtask

  task automatic waitRun(output int n);
    n = 0;
    while (!rstN && n < 2000) begin tick(); n++; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int n, expW, held;
    // R1 reset state
    tick(); tick();
    chk("R1 rstN", rstN, 0);
    chk("R1 cause", resetCause, 1);
    chk("R1 ioHiZ", ioHiZ, 0);
    chk("R1 wdtCount", wdtCount, 0);
    porPulse = 1'b0;
    waitRun(n);
    chk("R3 start-up length", n, OST + 1);

    // R2 power-up delay enabled, gated by slow ticks
    pwrtEnN = 1'b0;
    doPor();
    held = 0;
    for (int i = 0; i < 40; i++) begin tick(); if (rstN) held++; end
    chk("R2 held without ticks", held, 0);
    slowTick = 1'b1;
    waitRun(n);
    wdtClr = 1'b1;
    chk("R2 power-up plus start-up", n, PWRT + OST);
    pwrtEnN = 1'b1;

    // R4 brown-out duration sweep
    for (int len = 1; len <= 5; len++) begin
      brownFlag = 1'b1;
      repeat (len) tick();
      brownFlag = 1'b0;
      tick();
      chk("R4 rstN after brown pulse", rstN, (len < BOR) ? 1 : 0);
      chk("R4 brown cause bit", resetCause[1], (len < BOR) ? 0 : 1);
      chk("R9 brown leaves ioHiZ low", ioHiZ, 0);
      if (len >= BOR) begin waitRun(n); chk("R7 restart after brown", n, OST + 1); end
    end

    // R5 external reset width sweep
    for (int len = 1; len <= 5; len++) begin
      extRstN = 1'b0;
      repeat (len) tick();
      extRstN = 1'b1;
      tick();
      chk("R5 rstN after ext pulse", rstN, (len < MCL) ? 1 : 0);
      chk("R5 ext cause bit", resetCause[2], (len < MCL) ? 0 : 1);
      chk("R9 ioHiZ on ext reset", ioHiZ, (len < MCL) ? 0 : 1);
      if (len >= MCL) begin
        waitRun(n);
        chk("R5 release after ext", n, OST + 1);
        chk("R9 ioHiZ released", ioHiZ, 0);
      end
    end

    // R6 watchdog counting and clearing
    expW = 0;
    for (int i = 0; i < 20; i++) begin
      wdtClr = (i % 4 == 3);
      tick();
      expW = wdtClr ? 0 : expW + 1;
      chk("R6 wdtCount", wdtCount, expW);
      chk("R6 no reset while cleared", rstN, 1);
    end
    wdtClr = 1'b0;
    n = 0;
    while (rstN && n < 100) begin tick(); n++; end
    chk("R6 time-out length", n, WDT + 1);
    chk("R8 wdt cause bit", resetCause[3], 1);
    chk("R9 ioHiZ on wdt reset", ioHiZ, 1);
    chk("R6 held zero in reset", wdtCount, 0);
    waitRun(n);
    chk("R6 release after wdt", n, OST + 1);
    chk("R9 ioHiZ released after wdt", ioHiZ, 0);
    wdtClr = 1'b1;
    chk("R8 all causes sticky", resetCause, 15);

    // R7 restart during start-up, external reset
    doPor();
    chk("R8 cleared by power-on", resetCause, 1);
    repeat (4) tick();
    extRstN = 1'b0;
    repeat (MCL) tick();
    chk("R7 still in reset", rstN, 0);
    extRstN = 1'b1;
    waitRun(n);
    chk("R7 full restart after ext", n, OST + 2);
    chk("R8 cause after ext", resetCause, 5);

    // R7 restart during start-up, brown-out
    doPor();
    repeat (4) tick();
    brownFlag = 1'b1;
    repeat (BOR) tick();
    brownFlag = 1'b0;
    waitRun(n);
    chk("R7 full restart after brown", n, OST + 2);
    chk("R8 cause after brown", resetCause, 3);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule